// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers interrupt requests from a set of sources and drives one active-low request line to a processor. Software sets up each source through a small register bus. Each source has an enable bit, an edge-or-level mode bit, a priority from 0 (lowest) to 7 (highest) and a 32-bit vector word.

The processor acknowledges an interrupt by reading the acknowledge address. That read selects the best pending source and returns its vector word. It also clears the source's pending flag if the source is edge-triggered, and drops the request line. The priority of the selected source is pushed onto an internal stack of levels. The top of that stack is the level now in service.

A write to the end-of-interrupt address pops the stack. The request line rises again whenever an enabled pending source outranks the level in service, or whenever a source is pending and no level is in service. This allows nested preemption by strictly higher priorities.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, irq_n is 1 and rd_data is 0. Every source configuration word reads 0, which means disabled, level mode and priority 0.
- R2: Addresses 0..NUM_SRC-1 hold the source configuration words: bit 0 is enable, bit 1 is edge mode (1 = edge) and bits 6:4 are the priority. All other bits read 0. Addresses NUM_SRC..2*NUM_SRC-1 hold the 32-bit vector words. Address 2*NUM_SRC is the acknowledge read and address 2*NUM_SRC+1 is the end-of-interrupt write. A read's data appears on rd_data after the clock edge that samples rd_en.
- R3: irq_n goes to 0 when an enabled source is pending and no level is in service.
- R4: An acknowledge read returns the vector word of the enabled pending source with the highest priority. Among equal priorities, the lowest source number wins.
- R5: An acknowledge read drives irq_n to 1 on the next cycle. irq_n rises only because of an acknowledge read, and stays at 0 even if the pending source goes away before the read.
- R6: An edge-mode source becomes pending on a rising edge of its input and stays pending after the input falls. It stops being pending only when an acknowledge read selects it.
- R7: A level-mode source is pending exactly while its input is high. An acknowledge read does not clear it.
- R8: While a level is in service, irq_n asserts only for a pending source of strictly higher priority. Equal or lower priorities wait.
- R9: An end-of-interrupt write pops the stack. irq_n then reasserts if a pending source outranks the new top level, or if any source is pending and the stack is now empty. This holds even when that source's priority is not above the popped level.
- R10: A source whose enable bit is 0 never causes a request and is never selected.
- R11: The level stack holds 8 entries. An acknowledge read that would push a ninth entry changes nothing, and an end-of-interrupt write with an empty stack changes nothing.
- R12: An acknowledge read with no enabled pending source returns 0 and pushes no level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | NUM_SRC | Asynchronous interrupt inputs, one per source |
| addr | input | ADDR_W | Register word address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe; acknowledge side effects happen in this cycle |
| rd_data | output | 32 | Read data, registered |
| irq_n | output | 1 | Active-low interrupt request to the processor |

## Verification
The bench uses the default parameters: 32 sources, a two-stage input synchronizer and a 7-bit address. With eight priority levels, the stack depth of 8 can be reached with a few reads, so the bench covers pushing onto a full stack and popping an empty one. Having 32 sources allows equal-priority ties and distinct nested levels without reusing sources within a scenario. The two-stage synchronizer keeps the delay from an input change to irq_n short and bounded, so the bench waits a fixed number of cycles before it samples.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int LVL_W        = 3;
    localparam int NUM_LVL      = 1 << LVL_W;
    localparam int BUS_W        = 32;
    localparam int CFG_EN_BIT   = 0;
    localparam int CFG_EDGE_BIT = 1;
    localparam int CFG_PRIO_LSB = 4;

    typedef struct packed {
        logic [LVL_W-1:0] prio;
        logic             edge_mode;
        logic             enable;
    } src_cfg_t;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CFG,
        SEL_VEC,
        SEL_ACK,
        SEL_EOI
    } reg_sel_e;

    function automatic src_cfg_t cfg_from_word(input logic [BUS_W-1:0] w);
        src_cfg_t c;
        c.enable    = w[CFG_EN_BIT];
        c.edge_mode = w[CFG_EDGE_BIT];
        c.prio      = w[CFG_PRIO_LSB +: LVL_W];
        return c;
    endfunction

    function automatic logic [BUS_W-1:0] cfg_to_word(input src_cfg_t c);
        logic [BUS_W-1:0] w;
        w = '0;
        w[CFG_EN_BIT]              = c.enable;
        w[CFG_EDGE_BIT]            = c.edge_mode;
        w[CFG_PRIO_LSB +: LVL_W]   = c.prio;
        return w;
    endfunction

endpackage

// File: rtl/pic_src_gate.sv
module pic_src_gate #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic src_raw,
    input  logic edge_mode,
    input  logic clr,
    output logic pend
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic                   edge_pend_q;
    logic                   sync_s;
    logic                   rise;

    assign sync_s = sync_q[SYNC_STAGES-1];
    assign rise   = sync_s & ~last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q      <= '0;
            last_q      <= 1'b0;
            edge_pend_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], src_raw};
            last_q <= sync_s;
            if (!edge_mode)
                edge_pend_q <= 1'b0;
            else if (rise)
                edge_pend_q <= 1'b1;
            else if (clr)
                edge_pend_q <= 1'b0;
        end
    end

    assign pend = edge_mode ? edge_pend_q : sync_s;

    // R6: an acknowledged edge source with no fresh edge is no longer pending
    assert_edge_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (clr && edge_mode && !rise) |=> (!pend || !edge_mode));

    // R6: an edge source only becomes pending through a detected rise
    assert_edge_set_R6: assert property (@(posedge clk) disable iff (rst)
        (edge_mode && $past(edge_mode) && $rose(pend)) |-> $past(rise));

endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
    parameter int NUM_SRC = 32,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0]          req_i,
    input  logic [pic_pkg::LVL_W-1:0]   prio_i [NUM_SRC],
    output logic                        win_valid_o,
    output logic [IDX_W-1:0]            win_idx_o,
    output logic [pic_pkg::LVL_W-1:0]   win_prio_o
);
    // strict greater-than keeps the lowest index among equal priorities
    always_comb begin
        win_valid_o = 1'b0;
        win_idx_o   = '0;
        win_prio_o  = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (req_i[i] && (!win_valid_o || prio_i[i] > win_prio_o)) begin
                win_valid_o = 1'b1;
                win_idx_o   = IDX_W'(i);
                win_prio_o  = prio_i[i];
            end
        end
    end

endmodule

// File: rtl/pic_level_stack.sv
module pic_level_stack #(
    parameter int DEPTH  = 8,
    localparam int SP_W  = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      push,
    input  logic                      pop,
    input  logic [pic_pkg::LVL_W-1:0] push_lvl,
    output logic                      top_valid,
    output logic [pic_pkg::LVL_W-1:0] top_lvl
);
    logic [pic_pkg::LVL_W-1:0] mem [DEPTH];
    logic [SP_W-1:0]           sp;
    logic [SP_W-1:0]           sp_m1;

    assign sp_m1     = sp - 1'b1;
    assign top_valid = (sp != '0);
    assign top_lvl   = top_valid ? mem[sp_m1[IDX_W-1:0]] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            sp <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            case ({pop, push})
                2'b10: if (sp != '0) sp <= sp_m1;
                2'b01: if (sp != SP_W'(DEPTH)) begin
                    mem[sp[IDX_W-1:0]] <= push_lvl;
                    sp <= sp + 1'b1;
                end
                2'b11: if (sp == '0) begin
                    mem[0] <= push_lvl;
                    sp     <= SP_W'(1);
                end else begin
                    mem[sp_m1[IDX_W-1:0]] <= push_lvl;
                end
                default: ;
            endcase
        end
    end

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (rst)
        sp <= SP_W'(DEPTH));

    assert_pop_empty_R11: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && sp == '0) |=> (sp == '0));

    assert_push_grows_R11: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && sp != SP_W'(DEPTH)) |=> (sp == $past(sp) + 1'b1));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int NUM_SRC     = 32,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 7
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_SRC-1:0]         src_in,
    input  logic [ADDR_W-1:0]          addr,
    input  logic                       wr_en,
    input  logic [pic_pkg::BUS_W-1:0]  wr_data,
    input  logic                       rd_en,
    output logic [pic_pkg::BUS_W-1:0]  rd_data,
    output logic                       irq_n
);
    import pic_pkg::*;

    localparam int IDX_W = $clog2(NUM_SRC);
    localparam logic [ADDR_W-1:0] VEC_BASE = ADDR_W'(NUM_SRC);
    localparam logic [ADDR_W-1:0] ACK_ADDR = ADDR_W'(2 * NUM_SRC);
    localparam logic [ADDR_W-1:0] EOI_ADDR = ADDR_W'(2 * NUM_SRC + 1);

    src_cfg_t           cfg_q [NUM_SRC];
    logic [BUS_W-1:0]   vec_q [NUM_SRC];
    logic [LVL_W-1:0]   prio_arr [NUM_SRC];
    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] req_vec;

    reg_sel_e           sel;
    logic [IDX_W-1:0]   reg_idx;
    logic [ADDR_W-1:0]  vec_off;
    logic               ack, eoi;

    logic               win_valid;
    logic [IDX_W-1:0]   win_idx;
    logic [LVL_W-1:0]   win_prio;
    logic               top_valid;
    logic [LVL_W-1:0]   top_lvl;
    logic               want;
    logic               irq_q;

    // address decode
    assign vec_off = addr - VEC_BASE;
    always_comb begin
        sel     = SEL_NONE;
        reg_idx = addr[IDX_W-1:0];
        if (addr < VEC_BASE) begin
            sel = SEL_CFG;
        end else if (addr < ACK_ADDR) begin
            sel     = SEL_VEC;
            reg_idx = vec_off[IDX_W-1:0];
        end else if (addr == ACK_ADDR) begin
            sel = SEL_ACK;
        end else if (addr == EOI_ADDR) begin
            sel = SEL_EOI;
        end
    end

    assign ack = rd_en && (sel == SEL_ACK);
    assign eoi = wr_en && (sel == SEL_EOI);

    // configuration and vector storage
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                cfg_q[i] <= '0;
                vec_q[i] <= '0;
            end
        end else if (wr_en) begin
            if (sel == SEL_CFG) cfg_q[reg_idx] <= cfg_from_word(wr_data);
            if (sel == SEL_VEC) vec_q[reg_idx] <= wr_data;
        end
    end

    // per-source conditioning
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic clr_g;
        assign clr_g = ack && win_valid && (win_idx == IDX_W'(g));
        pic_src_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
            .clk       (clk),
            .rst       (rst),
            .src_raw   (src_in[g]),
            .edge_mode (cfg_q[g].edge_mode),
            .clr       (clr_g),
            .pend      (pend[g])
        );
        assign req_vec[g]  = pend[g] & cfg_q[g].enable;
        assign prio_arr[g] = cfg_q[g].prio;
    end

    pic_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .req_i       (req_vec),
        .prio_i      (prio_arr),
        .win_valid_o (win_valid),
        .win_idx_o   (win_idx),
        .win_prio_o  (win_prio)
    );

    pic_level_stack #(.DEPTH(NUM_LVL)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .push      (ack && win_valid),
        .pop       (eoi),
        .push_lvl  (win_prio),
        .top_valid (top_valid),
        .top_lvl   (top_lvl)
    );

    // request line: set when a source outranks the level in service, cleared only by acknowledge
    assign want = win_valid && (!top_valid || win_prio > top_lvl);

    always_ff @(posedge clk) begin
        if (rst)       irq_q <= 1'b0;
        else if (ack)  irq_q <= 1'b0;
        else if (want) irq_q <= 1'b1;
    end
    assign irq_n = ~irq_q;

    // read data
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            case (sel)
                SEL_CFG: rd_data <= cfg_to_word(cfg_q[reg_idx]);
                SEL_VEC: rd_data <= vec_q[reg_idx];
                SEL_ACK: rd_data <= win_valid ? vec_q[win_idx] : '0;
                default: rd_data <= '0;
            endcase
        end
    end

    assert_ack_drops_R5: assert property (@(posedge clk) disable iff (rst)
        ack |=> irq_n);

    assert_rise_needs_ack_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_n) |-> $past(ack));

    assert_winner_enabled_R10: assert property (@(posedge clk) disable iff (rst)
        win_valid |-> (req_vec[win_idx] && cfg_q[win_idx].enable));

    assert_empty_ack_R12: assert property (@(posedge clk) disable iff (rst)
        (ack && !win_valid) |=> (rd_data == '0));

endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;
    localparam int NS = 32;
    localparam int AW = 7;
    localparam logic [AW-1:0] ACK = AW'(2 * NS);
    localparam logic [AW-1:0] EOI = AW'(2 * NS + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] src_in = '0;
    logic [AW-1:0] addr = '0;
    logic          wr_en = 1'b0;
    logic [31:0]   wr_data = '0;
    logic          rd_en = 1'b0;
    logic [31:0]   rd_data;
    logic          irq_n;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    prio_irq_ctrl #(.NUM_SRC(NS), .SYNC_STAGES(2), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .src_in(src_in), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .irq_n(irq_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic set_src(input int i, input bit en, input bit edg, input int pr);
        bus_wr(AW'(i), {25'd0, 3'(pr), 2'b00, edg, en});
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 irq_n after reset", 32'(irq_n), 32'd1);
        chk("R1 rd_data after reset", rd_data, 32'd0);
        bus_rd(AW'(7), d);
        chk("R1 cfg reset value", d, 32'd0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        bus_wr(AW'(NS + 5), 32'hA5A5_0005);
        bus_rd(AW'(NS + 5), d);
        chk("R2 vector readback", d, 32'hA5A5_0005);
        bus_wr(AW'(5), 32'hFFFF_FFFF);
        bus_rd(AW'(5), d);
        chk("R2 cfg field mask", d, 32'h0000_0073);
        bus_wr(AW'(5), 32'h0);
        for (int i = 0; i < NS; i++) bus_wr(AW'(NS + i), 32'h1000 + i);
    endtask

    task automatic t_level();
        logic [31:0] d;
        set_src(3, 1, 0, 2);
        src_in[3] = 1'b1;
        cyc(6);
        chk("R3 irq_n asserts", 32'(irq_n), 32'd0);
        bus_rd(ACK, d);
        chk("R4 vector of src3", d, 32'h1003);
        cyc(2);
        chk("R5 irq_n drops after ack", 32'(irq_n), 32'd1);
        bus_wr(EOI, 0);
        cyc(4);
        chk("R7 level source still pending after eoi", 32'(irq_n), 32'd0);
        src_in[3] = 1'b0;
        cyc(6);
        chk("R5 irq_n held until ack", 32'(irq_n), 32'd0);
        bus_rd(ACK, d);
        chk("R12 empty ack returns 0", d, 32'd0);
        cyc(2);
        chk("R5 irq_n released", 32'(irq_n), 32'd1);
        set_src(3, 0, 0, 0);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        set_src(7, 1, 1, 1);
        @(negedge clk); src_in[7] = 1'b1;
        cyc(3);
        src_in[7] = 1'b0;
        cyc(6);
        chk("R6 edge latched after input fell", 32'(irq_n), 32'd0);
        bus_rd(ACK, d);
        chk("R6 vector of src7", d, 32'h1007);
        bus_wr(EOI, 0);
        cyc(6);
        chk("R6 edge pending cleared by ack", 32'(irq_n), 32'd1);
        set_src(7, 0, 0, 0);
    endtask

    task automatic t_prio();
        logic [31:0] d;
        set_src(10, 1, 0, 4);
        set_src(11, 1, 0, 6);
        set_src(12, 1, 0, 6);
        src_in[12:10] = 3'b111;
        cyc(6);
        bus_rd(ACK, d);
        chk("R4 tie goes to lowest index", d, 32'h100B);
        src_in[11] = 1'b0;
        cyc(6);
        chk("R8 equal priority does not preempt", 32'(irq_n), 32'd1);
        bus_wr(EOI, 0);
        cyc(4);
        chk("R9 reassert after pop", 32'(irq_n), 32'd0);
        bus_rd(ACK, d);
        chk("R4 next highest src12", d, 32'h100C);
        src_in[12] = 1'b0;
        bus_wr(EOI, 0);
        cyc(6);
        chk("R9 lower level source reasserts", 32'(irq_n), 32'd0);
        bus_rd(ACK, d);
        chk("R4 src10 last", d, 32'h100A);
        src_in[10] = 1'b0;
        bus_wr(EOI, 0);
        cyc(6);
        chk("R3 idle with nothing pending", 32'(irq_n), 32'd1);
        for (int i = 10; i <= 12; i++) set_src(i, 0, 0, 0);
    endtask

    task automatic t_nest();
        logic [31:0] d;
        set_src(20, 1, 0, 2);
        set_src(21, 1, 0, 5);
        set_src(22, 1, 0, 1);
        src_in[20] = 1'b1;
        cyc(6);
        bus_rd(ACK, d);
        chk("R4 src20 first", d, 32'h1014);
        src_in[22] = 1'b1;
        cyc(6);
        chk("R8 lower priority waits", 32'(irq_n), 32'd1);
        src_in[21] = 1'b1;
        cyc(6);
        chk("R8 higher priority preempts", 32'(irq_n), 32'd0);
        bus_rd(ACK, d);
        chk("R8 nested vector src21", d, 32'h1015);
        src_in[21] = 1'b0;
        bus_wr(EOI, 0);
        cyc(6);
        chk("R9 back at level 2, no reassert", 32'(irq_n), 32'd1);
        bus_wr(EOI, 0);
        cyc(4);
        chk("R9 reassert for source not above popped level", 32'(irq_n), 32'd0);
        bus_rd(ACK, d);
        chk("R9 src20 again", d, 32'h1014);
        src_in[20] = 1'b0;
        bus_wr(EOI, 0);
        cyc(4);
        bus_rd(ACK, d);
        chk("R8 waiting low source served", d, 32'h1016);
        src_in[22] = 1'b0;
        bus_wr(EOI, 0);
        cyc(6);
        chk("R9 all idle", 32'(irq_n), 32'd1);
        for (int i = 20; i <= 22; i++) set_src(i, 0, 0, 0);
    endtask

    task automatic t_stack();
        logic [31:0] d;
        set_src(30, 1, 0, 3);
        src_in[30] = 1'b1;
        cyc(6);
        for (int k = 0; k < 9; k++) bus_rd(ACK, d);
        for (int k = 0; k < 7; k++) bus_wr(EOI, 0);
        cyc(4);
        chk("R11 one level left after 9 pushes and 7 pops", 32'(irq_n), 32'd1);
        bus_wr(EOI, 0);
        cyc(4);
        chk("R11 stack empty after 8 pops", 32'(irq_n), 32'd0);
        bus_wr(EOI, 0);
        bus_rd(ACK, d);
        cyc(4);
        chk("R11 pop of empty ignored", 32'(irq_n), 32'd1);
        bus_wr(EOI, 0);
        cyc(4);
        chk("R11 single pop empties", 32'(irq_n), 32'd0);
        src_in[30] = 1'b0;
        cyc(4);
        bus_rd(ACK, d);
        set_src(30, 0, 0, 0);
    endtask

    task automatic t_disabled();
        logic [31:0] d;
        set_src(25, 0, 0, 7);
        src_in[25] = 1'b1;
        cyc(6);
        chk("R10 disabled source no request", 32'(irq_n), 32'd1);
        bus_rd(ACK, d);
        chk("R10 disabled source not selected", d, 32'd0);
        src_in[25] = 1'b0;
        set_src(26, 1, 0, 0);
        src_in[26] = 1'b1;
        cyc(6);
        chk("R12 empty ack pushed no level", 32'(irq_n), 32'd0);
        bus_rd(ACK, d);
        chk("R4 priority 0 source served", d, 32'h101A);
        src_in[26] = 1'b0;
        bus_wr(EOI, 0);
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(2);
        t_reset();
        t_regs();
        t_level();
        t_edge();
        t_prio();
        t_nest();
        t_stack();
        t_disabled();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule